// File: doc/BRIEF.md
# Programmable Interval Down-Counter Channel

This block is one channel of an interval timer. It runs on the system clock and counts on a clock-enable strobe, `tick_en`, that marks each edge of a slow timebase, nominally 1193180 Hz. Software reaches the channel through a byte-wide register port. It writes a reload value one byte at a time, least significant byte first, and picks one of two modes. In one-shot mode the channel expires once and then goes idle. In periodic mode it reloads itself at every expiry and keeps counting. A level `gate` input lets counting run or holds it paused.

On each expiry the channel raises `irq` for one timebase period so that an interrupt controller can catch it. No acknowledge input exists. The counter keeps running whether or not anyone services the request. A reload value of zero gives the longest period, 65536 timebase ticks, which is about 18.2 expiries per second at the nominal rate.

To read the running count safely, software issues a snapshot command. It then polls a ready flag in the status byte and reads the frozen copy low byte first. Both bytes therefore come from the same instant, and the live counter is not disturbed.

Top module: `interval_timer_channel`

## Requirements
- R1: After reset `irq` is low and the status byte (`bus_sel`=0) reads 0. Ticks with the gate high produce no expiry until a reload value has been written.
- R2: A write to `bus_sel`=1 stores a reload byte: the first write is the low byte and the second is the high byte. The value loads into the counter on the next tick after the high byte. With a reload value L, the first expiry comes L ticks after that loading tick.
- R3: A reload value of 0 counts as 65536 ticks.
- R4: In one-shot mode (control bit0 = 0) the channel expires once, then goes idle (status bit1 = 0) and produces no further expiry until a new value is written.
- R5: In periodic mode (control bit0 = 1) the counter reloads at each expiry, and expiries repeat every L ticks with no acknowledgement.
- R6: A tick that arrives while `gate` is low does not change the count, so each such tick delays the next expiry by one tick.
- R7: `irq` rises on the expiring tick and stays high until the next tick. It changes only on ticks or on a control write.
- R8: A control write with bit1 = 1 is a snapshot command that freezes the count. Status bit0 then reads 1. Reads of `bus_sel`=1 return the frozen low byte and then the high byte, and the second read clears status bit0. A snapshot command issued while a snapshot is still unread is ignored. Reads of `bus_sel`=1 return 0 when no snapshot is pending.
- R9: A control write with bit1 = 0 sets the mode from bit0 (status bit2 shows it). It also stops the counter, drops any pending load and resets the byte order so that the next reload byte is a low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe per timebase edge |
| gate | input | 1 | Count enable level |
| bus_sel | input | 1 | 0 selects control/status, 1 selects reload/snapshot data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; advances the snapshot byte order |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Expiry pulse toward the interrupt controller |

## Verification
Assertions check on every cycle the rules that relate neighbouring cycles:
- `irq` moves only on a tick or a control write.
- A paused or idle tick leaves the count unchanged.
- A one-shot expiry leaves the counter idle, and a periodic expiry reloads it.
- The count never exceeds 65536.
- A pending snapshot stays frozen.
- Writing the high byte always raises a load request.

Only the bench scenarios can show the end-to-end spacing of expiries, which needs many cycles:
- the first expiry L ticks after loading, and the interval L in periodic mode;
- the full 65536-tick period for a zero reload;
- the delay added by gated ticks;
- the byte order of snapshot reads;
- the effect of a mode write on a half-written reload value.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic periodic;
    logic armed;
    logic snap_ready;
  } status_t;

  function automatic logic [BYTE_W-1:0] pack_status(input status_t s);
    return {5'b0, s.periodic, s.armed, s.snap_ready};
  endfunction
endpackage

// File: rtl/tmr_reload_loader.sv
module tmr_reload_loader #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_wr,
  input  logic [7:0]       wdata,
  input  logic             restart,
  input  logic             load_ack,
  output logic [CNT_W-1:0] reload_val,
  output logic             load_req
);
  localparam int unsigned NB    = CNT_W / 8;
  localparam int unsigned IDX_W = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NB - 1);

  logic [CNT_W-1:0] stage_q, stage_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             req_q, req_d;
  logic             final_byte;

  assign final_byte = data_wr && !restart && (idx_q == LAST_IDX);

  always_comb begin
    stage_d  = stage_q;
    reload_d = reload_q;
    idx_d    = idx_q;
    req_d    = req_q;
    if (load_ack) req_d = 1'b0;
    if (restart) begin
      idx_d = '0;
      req_d = 1'b0;
    end else if (data_wr) begin
      stage_d[idx_q*8 +: 8] = wdata;
      if (idx_q == LAST_IDX) begin
        reload_d = stage_d;
        idx_d    = '0;
        req_d    = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      reload_q <= '0;
      idx_q    <= '0;
      req_q    <= 1'b0;
    end else begin
      stage_q  <= stage_d;
      reload_q <= reload_d;
      idx_q    <= idx_d;
      req_q    <= req_d;
    end
  end

  assign reload_val = reload_q;
  assign load_req   = req_q;

  // R2: the final byte always leaves a load request pending
  a_r2_hi_byte_requests_load: assert property (@(posedge clk) disable iff (!rst_n)
    final_byte |=> load_req);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           gate,
  input  logic           periodic,
  input  logic           disarm,
  input  logic           load_req,
  input  logic [CNT_W-1:0] reload_val,
  output logic           load_ack,
  output logic [CNT_W:0] count,
  output logic           armed,
  output logic           irq
);
  localparam logic [CNT_W:0] FULL_SPAN = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CNT_W:0] ONE       = {{CNT_W{1'b0}}, 1'b1};

  logic [CNT_W:0] count_q, count_d, reload_ext;
  logic           armed_q, armed_d, irq_q, irq_d;
  logic           load_now, step_en, expire;

  assign reload_ext = (reload_val == '0) ? FULL_SPAN : {1'b0, reload_val};
  assign load_now   = tick && load_req && !disarm;
  assign step_en    = tick && !load_now && !disarm && armed_q && gate;
  assign expire     = step_en && (count_q == ONE);

  always_comb begin
    count_d = count_q;
    armed_d = armed_q;
    irq_d   = irq_q;
    if (disarm) begin
      count_d = '0;
      armed_d = 1'b0;
      irq_d   = 1'b0;
    end else if (load_now) begin
      count_d = reload_ext;
      armed_d = 1'b1;
      irq_d   = 1'b0;
    end else if (tick) begin
      irq_d = 1'b0;
      if (expire) begin
        irq_d = 1'b1;
        if (periodic) begin
          count_d = reload_ext;
        end else begin
          count_d = '0;
          armed_d = 1'b0;
        end
      end else if (step_en) begin
        count_d = count_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      armed_q <= armed_d;
      irq_q   <= irq_d;
    end
  end

  assign load_ack = load_now;
  assign count    = count_q;
  assign armed    = armed_q;
  assign irq      = irq_q;

  // R3: count never exceeds the full span
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= FULL_SPAN);
  // R6: no tick, paused gate or idle channel leaves the count alone
  a_r6_hold_when_paused: assert property (@(posedge clk) disable iff (!rst_n)
    (!disarm && !load_now && !(tick && gate)) |=> $stable(count_q));
  // R7: irq only moves on a tick or a control write
  a_r7_irq_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(irq_q) |-> $past(tick || disarm));
  // R4: one-shot expiry leaves the channel idle at zero
  a_r4_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !periodic) |=> (count_q == '0 && !armed_q && irq_q));
  // R5: periodic expiry reloads and stays armed
  a_r5_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic) |=> (armed_q && irq_q && count_q == $past(reload_ext)));
endmodule

// File: rtl/tmr_snapshot.sv
module tmr_snapshot #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snap_cmd,
  input  logic [CNT_W-1:0] live_count,
  input  logic             rd_strobe,
  output logic             ready,
  output logic [7:0]       rd_byte
);
  localparam int unsigned NB    = CNT_W / 8;
  localparam int unsigned IDX_W = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NB - 1);

  logic [CNT_W-1:0] hold_q, hold_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             ready_q, ready_d;

  always_comb begin
    hold_d  = hold_q;
    idx_d   = idx_q;
    ready_d = ready_q;
    if (ready_q) begin
      if (rd_strobe) begin
        if (idx_q == LAST_IDX) begin
          ready_d = 1'b0;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
    end else if (snap_cmd) begin
      hold_d  = live_count;
      ready_d = 1'b1;
      idx_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      idx_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      idx_q   <= idx_d;
      ready_q <= ready_d;
    end
  end

  assign ready   = ready_q;
  assign rd_byte = ready_q ? hold_q[idx_q*8 +: 8] : 8'h00;

  // R8: a pending snapshot stays frozen until fully read
  a_r8_snapshot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> $stable(hold_q));
endmodule

// File: rtl/interval_timer_channel.sv
module interval_timer_channel
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       gate,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  logic             ctrl_wr, data_wr, snap_cmd, mode_wr, data_rd;
  logic             periodic_q, periodic_d;
  logic             load_req, load_ack, armed, snap_ready;
  logic [CNT_W-1:0] reload_val;
  logic [CNT_W:0]   count;
  logic [7:0]       snap_byte;
  status_t          stat;

  assign ctrl_wr  = bus_wr && !bus_sel;
  assign data_wr  = bus_wr && bus_sel;
  assign snap_cmd = ctrl_wr && bus_wdata[1];
  assign mode_wr  = ctrl_wr && !bus_wdata[1];
  assign data_rd  = bus_rd && bus_sel;

  always_comb begin
    periodic_d = periodic_q;
    if (mode_wr) periodic_d = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) periodic_q <= 1'b0;
    else        periodic_q <= periodic_d;
  end

  tmr_reload_loader #(.CNT_W(CNT_W)) u_loader (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .wdata(bus_wdata),
    .restart(mode_wr), .load_ack(load_ack),
    .reload_val(reload_val), .load_req(load_req)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .gate(gate),
    .periodic(periodic_q), .disarm(mode_wr), .load_req(load_req),
    .reload_val(reload_val), .load_ack(load_ack), .count(count),
    .armed(armed), .irq(irq)
  );

  tmr_snapshot #(.CNT_W(CNT_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .snap_cmd(snap_cmd),
    .live_count(count[CNT_W-1:0]), .rd_strobe(data_rd),
    .ready(snap_ready), .rd_byte(snap_byte)
  );

  always_comb begin
    stat.periodic   = periodic_q;
    stat.armed      = armed;
    stat.snap_ready = snap_ready;
    bus_rdata = bus_sel ? snap_byte : pack_status(stat);
  end

  // R9: a mode write leaves the channel disarmed
  a_r9_mode_write_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (!armed && !irq));
endmodule

// File: tb/interval_timer_channel_bench.sv
module interval_timer_channel_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_en = 1'b0, gate = 1'b1, bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic irq;
  int checks = 0, errors = 0;
  int n_irq, first_irq, last_irq;
  logic [7:0] rb;

  always #2 clk = ~clk;

  interval_timer_channel u_interval_timer_channel (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic sel, input logic [7:0] d);
    @(negedge clk); bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic sel, output logic [7:0] d);
    @(negedge clk); bus_sel = sel; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    n_irq = 0; first_irq = 0; last_irq = 0;
    @(negedge clk); tick_en = 1'b1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (irq) begin
        n_irq++;
        if (first_irq == 0) first_irq = i;
        last_irq = i;
      end
    end
    tick_en = 1'b0;
  endtask

  task automatic setup(input logic per, input logic [15:0] val);
    bus_write(1'b0, {7'b0, per});
    bus_write(1'b1, val[7:0]);
    bus_write(1'b1, val[15:8]);
  endtask

  function automatic int span(input int v);
    return (v == 0) ? 65536 : v;
  endfunction

  function automatic int exp_count(input logic per, input int l, input int t);
    int k = (t - 1) / l;
    return per ? k : ((k > 0) ? 1 : 0);
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", irq, 0);
    bus_read(1'b0, rb); check("R1 status", rb, 0);
    run_ticks(20); check("R1 no expiry", n_irq, 0);

    // R2 / R4 one-shot, L = 12
    setup(1'b0, 16'd12);
    run_ticks(40);
    check("R2 first expiry", first_irq, 13);
    check("R4 single expiry", n_irq, 1);
    bus_read(1'b0, rb); check("R4 idle status", rb, 0);

    // R5 periodic, L = 7
    setup(1'b1, 16'd7);
    run_ticks(1 + 7 * 5);
    check("R5 count", n_irq, 5);
    check("R5 last", last_irq, 36);

    // R7 pulse width
    setup(1'b0, 16'd3);
    run_ticks(4); check("R7 rises", irq, 1);
    repeat (5) @(negedge clk);
    check("R7 held between ticks", irq, 1);
    run_ticks(1); check("R7 falls next tick", irq, 0);

    // R6 gate
    setup(1'b0, 16'd10);
    run_ticks(4);
    gate = 1'b0; run_ticks(5); check("R6 paused", n_irq, 0);
    gate = 1'b1; run_ticks(10); check("R6 delayed", first_irq, 7);

    // R8 snapshot
    setup(1'b1, 16'd300);
    run_ticks(31);
    bus_write(1'b0, 8'h02);
    bus_read(1'b0, rb); check("R8 ready", rb & 1, 1);
    run_ticks(10);
    bus_write(1'b0, 8'h02);
    bus_read(1'b1, rb); check("R8 low byte", rb, 270 & 8'hFF);
    bus_read(1'b1, rb); check("R8 high byte", rb, 270 >> 8);
    bus_read(1'b0, rb); check("R8 ready cleared", rb & 1, 0);
    bus_read(1'b1, rb); check("R8 empty read", rb, 0);

    // R9 mode write stops counter and resets byte order
    setup(1'b1, 16'd5);
    run_ticks(3);
    bus_write(1'b1, 8'h22);
    bus_write(1'b0, 8'h01);
    bus_read(1'b0, rb); check("R9 status", rb, 4);
    run_ticks(20); check("R9 stopped", n_irq, 0);
    bus_write(1'b1, 8'h05);
    bus_write(1'b1, 8'h00);
    run_ticks(8); check("R9 low byte first", first_irq, 6);

    // R3 zero reload
    setup(1'b0, 16'd0);
    run_ticks(65547);
    check("R3 full span", first_irq, span(0) + 1);
    check("R3 one expiry", n_irq, 1);

    // random mix
    for (int it = 0; it < 16; it++) begin
      logic per = 1'($urandom % 2);
      int l = 1 + int'($urandom % 40);
      int t = 3 * l + 1 + int'($urandom % 10);
      setup(per, 16'(l));
      run_ticks(t);
      check(per ? "R5 random count" : "R4 random count", n_irq, exp_count(per, l, t));
      check("R2 random first", first_irq, l + 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule